// File: doc/BRIEF.md
# Write and Read Fault Monitor

This block supervises a head amplifier and drives one fault flag. It decodes the operating mode from three control inputs: a power-on level, an active level and a read/write select. In write mode it treats several conditions as faults: an open write head, a write head shorted to ground and a supply out of tolerance. It also times the differential write-data input and raises a fault when that input stops toggling often enough. In read mode it reports an open or shorted MR head, and each of these two detectors counts only while its own enable input is set.

The fault flag is high-active in write mode and low-active in read mode. In sleep and idle it rests low. A bank-write override masks every detector, the supply check included. Every input passes through a two-flop synchroniser before the block uses it. When the decoded mode changes, the write-data gap counter and the internal fault register are cleared, so a fault from the previous mode is never reported in the new one.

Top module: `wr_rd_fault_mon`

## Requirements
- R1: In write mode (`pwr_on_i`=1, `active_i`=1, `rd_wr_n_i`=0), `fault_o` is 1 when any of `wr_open_i`, `wr_gnd_short_i` or `supply_low_i` is 1, and 0 otherwise (write-data activity permitting). The MR inputs have no effect in this mode.
- R2: In write mode, valid write-data transitions spaced at most `WD_MAX_GAP` clock cycles apart never raise `fault_o`. Spacing of `WD_MAX_GAP`+1 cycles or more raises it.
- R3: In read mode (`pwr_on_i`=1, `active_i`=1, `rd_wr_n_i`=1), `fault_o` is 0 on an enabled MR open or MR short condition, and 1 otherwise. The write-fault inputs have no effect in this mode.
- R4: `mr_open_i` counts only while `mr_open_en_i`=1, and `mr_short_i` counts only while `mr_short_en_i`=1.
- R5: While `bank_wr_i`=1, no fault is reported: `fault_o` is 0 in write mode and 1 in read mode.
- R6: In sleep (`pwr_on_i`=0) and in idle (`pwr_on_i`=1, `active_i`=0), `fault_o` is 0 whatever the condition inputs are.
- R7: A change of decoded mode clears the gap counter and the fault register. On entering write from a read fault, `fault_o` is 0 from the third clock edge onward.
- R8: A level condition appears on `fault_o` after the third rising edge following the input change. After write mode is entered with static write data, `fault_o` rises after edge `WD_MAX_GAP`+4, counting from the edge that follows the mode change.
- R9: During and right after reset, `fault_o` is 0.
- R10: A write-data state with `wd_p_i` equal to `wd_n_i` is invalid and counts as no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_i | input | 1 | 0 selects sleep |
| active_i | input | 1 | 0 selects idle when powered |
| rd_wr_n_i | input | 1 | 1 selects read, 0 selects write |
| wd_p_i | input | 1 | Write data, true leg |
| wd_n_i | input | 1 | Write data, complement leg |
| wr_open_i | input | 1 | Write head open indication |
| wr_gnd_short_i | input | 1 | Write head shorted to ground |
| supply_low_i | input | 1 | Supply out of tolerance |
| mr_open_i | input | 1 | MR head open indication |
| mr_short_i | input | 1 | MR head short indication |
| mr_open_en_i | input | 1 | Enable for MR open detection |
| mr_short_en_i | input | 1 | Enable for MR short detection |
| bank_wr_i | input | 1 | Bank-write override, masks all detectors |
| fault_o | output | 1 | Fault flag, polarity set by mode |

## Verification
A level condition passes through two synchroniser flops and then the fault register, so it shows on `fault_o` after the third rising edge. A mode change takes the same three edges, and the first fault evaluated in the new mode follows one edge later. The gap fault needs the counter to reach `WD_MAX_GAP`, which puts it `WD_MAX_GAP`+4 edges after the mode edge. The vector loop holds each pattern for six cycles before it samples. The directed checks count edges exactly and sample at the falling edge on both sides of the due edge. Gap-fault pulses are checked by watching `fault_o` over a window of several periods.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } fmon_mode_e;

  function automatic fmon_mode_e decode_mode(logic pwr_on, logic active, logic rd_wr_n);
    if (!pwr_on)      return MODE_SLEEP;
    else if (!active) return MODE_IDLE;
    else if (rd_wr_n) return MODE_READ;
    else              return MODE_WRITE;
  endfunction

  // next value of the write-data gap counter
  function automatic int unsigned gap_step(int unsigned cnt, logic hit, logic run,
                                           logic clr, int unsigned lim);
    if (clr || !run)  return 0;
    else if (hit)     return 0;
    else if (cnt < lim) return cnt + 1;
    else              return lim;
  endfunction

  function automatic logic write_fault(logic open_h, logic gnd_short, logic sup_low,
                                       logic slow_wd);
    return open_h | gnd_short | sup_low | slow_wd;
  endfunction

  function automatic logic read_fault(logic open_h, logic short_h,
                                      logic open_en, logic short_en);
    return (open_h & open_en) | (short_h & short_en);
  endfunction

  // pin level for an internal active-high fault in a given mode
  function automatic logic pin_level(fmon_mode_e m, logic flt);
    case (m)
      MODE_WRITE: return flt;
      MODE_READ:  return ~flt;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fmon_sync.sv
module fmon_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fmon_wd_timer.sv
module fmon_wd_timer
  import fmon_pkg::*;
#(
  parameter int MAX_GAP = 16,
  localparam int CW     = $clog2(MAX_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_p_i,
  input  logic          wd_n_i,
  input  logic          run_i,
  input  logic          clr_i,
  output logic          edge_o,
  output logic [CW-1:0] cnt_o,
  output logic          slow_o
);
  logic          wd_prev_q;
  logic          wd_valid;
  logic [CW-1:0] cnt_q;

  assign wd_valid = wd_p_i ^ wd_n_i;
  assign edge_o   = run_i & wd_valid & (wd_p_i != wd_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_prev_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (wd_valid) wd_prev_q <= wd_p_i;
      cnt_q <= CW'(gap_step(32'(cnt_q), edge_o, run_i, clr_i, 32'(MAX_GAP)));
    end
  end

  assign cnt_o  = cnt_q;
  assign slow_o = run_i & (cnt_q == CW'(MAX_GAP));
endmodule

// File: rtl/fmon_fault_core.sv
module fmon_fault_core
  import fmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fmon_mode_e mode_s_i,
  input  logic       wr_open_i,
  input  logic       wr_gnd_i,
  input  logic       sup_low_i,
  input  logic       slow_i,
  input  logic       mr_open_i,
  input  logic       mr_short_i,
  input  logic       open_en_i,
  input  logic       short_en_i,
  input  logic       bank_i,
  output fmon_mode_e mode_q_o,
  output logic       chg_o,
  output logic       fault_q_o
);
  fmon_mode_e mode_q;
  logic       fault_q;
  logic       fault_d;

  assign chg_o = (mode_s_i != mode_q);

  always_comb begin
    fault_d = 1'b0;
    if (!chg_o && !bank_i) begin
      case (mode_s_i)
        MODE_WRITE: fault_d = write_fault(wr_open_i, wr_gnd_i, sup_low_i, slow_i);
        MODE_READ:  fault_d = read_fault(mr_open_i, mr_short_i, open_en_i, short_en_i);
        default:    fault_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SLEEP;
      fault_q <= 1'b0;
    end else begin
      mode_q  <= mode_s_i;
      fault_q <= fault_d;
    end
  end

  assign mode_q_o  = mode_q;
  assign fault_q_o = fault_q;
endmodule

// File: rtl/wr_rd_fault_mon.sv
module wr_rd_fault_mon
  import fmon_pkg::*;
#(
  parameter int WD_MAX_GAP  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on_i,
  input  logic active_i,
  input  logic rd_wr_n_i,
  input  logic wd_p_i,
  input  logic wd_n_i,
  input  logic wr_open_i,
  input  logic wr_gnd_short_i,
  input  logic supply_low_i,
  input  logic mr_open_i,
  input  logic mr_short_i,
  input  logic mr_open_en_i,
  input  logic mr_short_en_i,
  input  logic bank_wr_i,
  output logic fault_o
);
  localparam int CW = $clog2(WD_MAX_GAP + 1);

  // bit positions inside the synchroniser vector
  localparam int IX_PWR   = 0;
  localparam int IX_ACT   = 1;
  localparam int IX_RW    = 2;
  localparam int IX_WDP   = 3;
  localparam int IX_WDN   = 4;
  localparam int IX_WOPEN = 5;
  localparam int IX_WGND  = 6;
  localparam int IX_SUP   = 7;
  localparam int IX_MRO   = 8;
  localparam int IX_MRS   = 9;
  localparam int IX_OEN   = 10;
  localparam int IX_SEN   = 11;
  localparam int IX_BANK  = 12;
  localparam int NSYNC    = 13;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn;

  assign raw_in = {bank_wr_i, mr_short_en_i, mr_open_en_i, mr_short_i, mr_open_i,
                   supply_low_i, wr_gnd_short_i, wr_open_i, wd_n_i, wd_p_i,
                   rd_wr_n_i, active_i, pwr_on_i};

  fmon_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  // named internal events, used by the checker
  fmon_mode_e    mode_s;
  fmon_mode_e    mode_q;
  logic          mode_chg;
  logic          wd_run;
  logic          wd_edge;
  logic [CW-1:0] gap_cnt;
  logic          wd_slow;
  logic          bank_s;
  logic          fault_q;

  assign mode_s = decode_mode(syn[IX_PWR], syn[IX_ACT], syn[IX_RW]);
  assign wd_run = (mode_s == MODE_WRITE);
  assign bank_s = syn[IX_BANK];

  fmon_wd_timer #(.MAX_GAP(WD_MAX_GAP)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .wd_p_i (syn[IX_WDP]),
    .wd_n_i (syn[IX_WDN]),
    .run_i  (wd_run),
    .clr_i  (mode_chg),
    .edge_o (wd_edge),
    .cnt_o  (gap_cnt),
    .slow_o (wd_slow)
  );

  fmon_fault_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_s_i   (mode_s),
    .wr_open_i  (syn[IX_WOPEN]),
    .wr_gnd_i   (syn[IX_WGND]),
    .sup_low_i  (syn[IX_SUP]),
    .slow_i     (wd_slow),
    .mr_open_i  (syn[IX_MRO]),
    .mr_short_i (syn[IX_MRS]),
    .open_en_i  (syn[IX_OEN]),
    .short_en_i (syn[IX_SEN]),
    .bank_i     (bank_s),
    .mode_q_o   (mode_q),
    .chg_o      (mode_chg),
    .fault_q_o  (fault_q)
  );

  assign fault_o = pin_level(mode_q, fault_q);
endmodule

// File: rtl/fmon_checker.sv
module fmon_checker
  import fmon_pkg::*;
#(
  parameter int MAX_GAP = 16,
  localparam int CW     = $clog2(MAX_GAP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input fmon_mode_e    mode_q,
  input logic          mode_chg,
  input logic          fault_q,
  input logic          fault_o,
  input logic [CW-1:0] gap_cnt,
  input logic          wd_slow,
  input logic          bank_s
);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP || mode_q == MODE_IDLE) |-> !fault_o);

  assert_bank_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_s |=> !fault_q);

  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= CW'(MAX_GAP));

  assert_slow_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_slow && !bank_s && !mode_chg) |=> fault_o);

  assert_mode_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (gap_cnt == '0 && !fault_q));

  assert_read_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && !fault_q) |-> fault_o);

  assert_reset_low_R9: assert property (@(posedge clk)
    !rst_n |-> !fault_o);
endmodule

bind wr_rd_fault_mon fmon_checker #(.MAX_GAP(WD_MAX_GAP)) u_fmon_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_q   (mode_q),
  .mode_chg (mode_chg),
  .fault_q  (fault_q),
  .fault_o  (fault_o),
  .gap_cnt  (gap_cnt),
  .wd_slow  (wd_slow),
  .bank_s   (bank_s)
);

// File: tb/test_wr_rd_fault_mon.sv
module test_wr_rd_fault_mon;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 16;
  localparam int NVEC       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 0, active = 0, rd_wr_n = 0, wd_p = 1, wd_n = 0;
  logic wr_open = 0, wr_gnd = 0, sup_low = 0, mr_open = 0, mr_short = 0;
  logic open_en = 0, short_en = 0, bank = 0;
  logic fault_o;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  bit  tog_on = 0;
  int  tog_gap = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_rd_fault_mon #(.WD_MAX_GAP(GAP)) i_wr_rd_fault_mon (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on), .active_i(active),
    .rd_wr_n_i(rd_wr_n), .wd_p_i(wd_p), .wd_n_i(wd_n), .wr_open_i(wr_open),
    .wr_gnd_short_i(wr_gnd), .supply_low_i(sup_low), .mr_open_i(mr_open),
    .mr_short_i(mr_short), .mr_open_en_i(open_en), .mr_short_en_i(short_en),
    .bank_wr_i(bank), .fault_o(fault_o)
  );

  // {pwr, act, rw, wopen, wgnd, suplow, mro, mrs, oen, sen, bank, expected}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b110_000_0000_0_0, // write, clean
    12'b110_100_0000_0_1, // write, open head
    12'b110_010_0000_0_1, // write, ground short
    12'b110_001_0000_0_1, // write, supply low
    12'b110_001_0000_1_0, // write, bank override
    12'b110_000_1111_0_0, // write, MR faults ignored
    12'b111_000_0000_0_1, // read, clean
    12'b111_000_1010_0_0, // read, open enabled
    12'b111_000_0101_0_0, // read, short enabled
    12'b111_000_1001_0_1, // read, open not enabled
    12'b111_000_0110_0_1, // read, short not enabled
    12'b111_000_1111_1_1, // read, bank override
    12'b111_111_0000_0_1, // read, write faults ignored
    12'b100_100_0000_0_0, // idle
    12'b011_000_1010_0_0, // sleep
    12'b101_000_1010_0_0  // idle, read select
  };

  function automatic string vec_req(int i);
    if (i == 4 || i == 11) return "R5";
    if (i <= 5)            return "R1";
    if (i == 9 || i == 10) return "R4";
    if (i <= 12)           return "R3";
    return "R6";
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: fault_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // watch fault_o for n cycles; returns 1 if it was ever high
  task automatic watch(int n, output logic seen);
    seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (fault_o) seen = 1;
    end
  endtask

  // write-data toggler, one flip every tog_gap cycles
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      if (tog_on) begin
        k++;
        if (k >= tog_gap) begin
          wd_p = ~wd_p; wd_n = ~wd_p; k = 0;
        end
      end else k = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic seen;
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9", fault_o, 1'b0);
    pwr_on = 1; active = 1; rd_wr_n = 0; wr_open = 1;
    edges(4);
    check("R9", fault_o, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R9", fault_o, 1'b0);
    wr_open = 0;

    // vector table, write data toggling well inside the limit
    tog_gap = 4; tog_on = 1;
    for (int i = 0; i < NVEC; i++) begin
      {pwr_on, active, rd_wr_n, wr_open, wr_gnd, sup_low,
       mr_open, mr_short, open_en, short_en, bank} = VEC[i][11:1];
      edges(6);
      check(vec_req(i), fault_o, VEC[i][0]);
    end

    // R8 level latency in write mode
    {pwr_on, active, rd_wr_n, wr_open, wr_gnd, sup_low, mr_open, mr_short,
     open_en, short_en, bank} = 11'b110_000_0000_0;
    edges(8);
    wr_open = 1;
    edges(2);
    check("R8", fault_o, 1'b0);
    edges(1);
    check("R8", fault_o, 1'b1);
    wr_open = 0;
    edges(4);

    // R2 gap boundary
    tog_gap = GAP;
    edges(2 * GAP);
    watch(4 * GAP, seen);
    check("R2", seen, 1'b0);
    tog_gap = GAP + 1;
    watch(4 * GAP, seen);
    check("R2", seen, 1'b1);
    tog_gap = 4;
    edges(2 * GAP);
    check("R2", fault_o, 1'b0);

    // R7 read fault cleared on entry to write
    rd_wr_n = 1; mr_open = 1; open_en = 1;
    edges(6);
    check("R3", fault_o, 1'b0);
    rd_wr_n = 0;
    edges(3);
    check("R7", fault_o, 1'b0);
    edges(3);
    check("R7", fault_o, 1'b0);
    mr_open = 0; open_en = 0;

    // R8 gap fault timing from write entry, static write data
    rd_wr_n = 1;
    edges(6);
    tog_on = 0;
    wd_p = 1; wd_n = 0;
    edges(6);
    rd_wr_n = 0;
    edges(GAP + 3);
    check("R8", fault_o, 1'b0);
    edges(1);
    check("R8", fault_o, 1'b1);

    // R10 invalid states are not transitions
    rd_wr_n = 1;
    edges(6);
    rd_wr_n = 0;
    for (int j = 0; j < 3 * GAP; j++) begin
      @(negedge clk);
      wd_n = (j % 2 == 0);
    end
    wd_n = 0;
    check("R10", fault_o, 1'b1);

    // R5 bank override in write with static data
    bank = 1;
    edges(4);
    check("R5", fault_o, 1'b0);
    bank = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule